// File: doc/BRIEF.md
# Software flow-control receive character detector

This block follows a UART receiver's deserializer and looks at every received character once. It decides three things for each character. First, whether the character is a software flow-control command that halts or resumes the local transmitter. Second, whether it equals a programmable special character. Third, whether it goes into the receive FIFO. Four programmable match characters are compared against each byte: a primary and a secondary resume character, and a primary and a secondary halt character. A 2-bit mode input selects which of them take part in flow control.

The special character has no register of its own. It reuses the secondary halt character. When detection is enabled, a hit sets a sticky status bit, and it can raise a one-cycle interrupt pulse. In paired mode, a halt or resume takes effect only when a primary character is followed directly by its secondary partner. If the pair is broken, both bytes go to the FIFO as ordinary data, one per cycle.

Each byte's outcome appears one clock after its valid strobe. A broken pair produces a second FIFO write one clock later. The design assumes that rx_valid is never asserted in the clock directly after a valid strobe. It also assumes that the mode does not change while the first byte of a pair is being held.

Top module: `xon_xoff_rx_detect`

## Requirements
- R1: With fc_mode = 2'b00, every byte is written to the FIFO (fifo_wr high, fifo_data equal to the byte) in the cycle after its rx_valid. tx_halt is left unchanged and no xoff_irq pulse is issued.
- R2: With fc_mode = 2'b10, a byte equal to off1_char sets tx_halt and pulses xoff_irq. A byte equal to on1_char clears tx_halt. Neither of these is written. Any other byte is written. When the two characters are equal, halt takes priority.
- R3: With fc_mode = 2'b01, the rule of R2 applies to off2_char and on2_char.
- R4: With fc_mode = 2'b11, off1_char followed directly by off2_char sets tx_halt and pulses xoff_irq in the cycle after the second byte. on1_char followed directly by on2_char clears tx_halt. No byte of a completed pair is written.
- R5: In fc_mode = 2'b11, a held first character followed by a byte that does not complete its pair is handled as ordinary data. The held byte is written in the cycle after the second byte's strobe, and the second byte is written one cycle later. There is no flow-control action, and the pair state is cleared.
- R6: With spec_en high, a byte equal to off2_char sets spec_stat in the cycle after its strobe. It also pulses spec_irq when spec_ie is high. Outside mode 2'b01, the byte is still written, unless it completes a paired halt.
- R7: In fc_mode = 2'b01 with spec_en high, a byte equal to off2_char is not written. It raises xoff_irq and, when spec_ie is high, spec_irq in the same cycle.
- R8: spec_stat stays set until stat_clr is sampled high. A special-character hit in the same cycle as stat_clr leaves it set.
- R9: xoff_irq and spec_irq are single-cycle pulses, issued only in the cycle after an rx_valid strobe.
- R10: Reset (rst_n low) clears tx_halt, spec_stat, the pulses, the FIFO write and any held first character of a pair.
- R11: tx_halt stays set across ordinary data until a resume character valid for the current mode is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | DATA_W | Received character |
| rx_valid | input | 1 | One-cycle strobe marking rx_data valid |
| on1_char | input | DATA_W | Primary resume character |
| on2_char | input | DATA_W | Secondary resume character |
| off1_char | input | DATA_W | Primary halt character |
| off2_char | input | DATA_W | Secondary halt character, also the special character |
| fc_mode | input | 2 | 00 off, 10 primary, 01 secondary, 11 paired |
| spec_en | input | 1 | Special-character detection enable |
| spec_ie | input | 1 | Special-character interrupt enable |
| stat_clr | input | 1 | Clears spec_stat |
| fifo_wr | output | 1 | Receive FIFO write enable |
| fifo_data | output | DATA_W | Byte to write to the FIFO |
| tx_halt | output | 1 | Local transmitter halted |
| xoff_irq | output | 1 | Halt-detected pulse |
| spec_irq | output | 1 | Special-character pulse |
| spec_stat | output | 1 | Sticky special-character status |

## Verification
The hardest situations to reach are the interactions around a held first character in paired mode. These are a break by the wrong partner, a break by a byte that is itself the special character, and a reset that arrives while a byte is held. Directed sequences place a primary character and then each kind of follower. The random phase draws most bytes from the four match characters, so pairs form and break often. Mode and enable changes are deferred until no pair is held, so every mode code is crossed with both enable settings.

// File: rtl/xfc_pkg.sv
// Shared types for the software flow-control receive detector.
// Assumes the mode encoding 00 off, 01 secondary, 10 primary, 11 paired.
package xfc_pkg;
    localparam int NUM_CHARS = 4;
    localparam int IDX_ON1  = 0;
    localparam int IDX_ON2  = 1;
    localparam int IDX_OFF1 = 2;
    localparam int IDX_OFF2 = 3;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_SEC  = 2'b01,
        MODE_PRI  = 2'b10,
        MODE_PAIR = 2'b11
    } fc_mode_e;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'b00,
        HOLD_ON   = 2'b01,
        HOLD_OFF  = 2'b10
    } hold_e;

    typedef struct packed {
        logic wr_cur;
        logic flush;
        logic set_halt;
        logic clr_halt;
        logic xoff_ev;
        logic spec_ev;
        logic arm_on;
        logic arm_off;
        logic disarm;
    } verdict_t;
endpackage

// File: rtl/xfc_match.sv
// Equality comparators: one per programmable match character.
// Assumes all characters share the width DATA_W.
module xfc_match
    import xfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]                 rx_data,
    input  logic [NUM_CHARS-1:0][DATA_W-1:0]  chars,
    output logic [NUM_CHARS-1:0]              hit
);
    genvar g;
    generate
        for (g = 0; g < NUM_CHARS; g++) begin : g_cmp
            // Bitwise compare of the received byte against one character.
            always_comb hit[g] = (rx_data == chars[g]);
        end
    endgenerate
endmodule

// File: rtl/xfc_decide.sv
// Per-byte decision logic: maps mode, hold state and match hits to actions.
// Purely combinational; the caller qualifies the result with rx_valid.
module xfc_decide
    import xfc_pkg::*;
(
    input  logic [1:0]           mode,
    input  hold_e                hold,
    input  logic [NUM_CHARS-1:0] hit,
    input  logic                 spec_en,
    output verdict_t             vd
);
    // Select the action for the current byte according to the mode.
    always_comb begin
        vd = '0;
        vd.spec_ev = spec_en & hit[IDX_OFF2];
        unique case (fc_mode_e'(mode))
            MODE_OFF: vd.wr_cur = 1'b1;
            MODE_PRI: begin
                if (hit[IDX_OFF1]) begin
                    vd.set_halt = 1'b1;
                    vd.xoff_ev  = 1'b1;
                end else if (hit[IDX_ON1]) begin
                    vd.clr_halt = 1'b1;
                end else begin
                    vd.wr_cur = 1'b1;
                end
            end
            MODE_SEC: begin
                if (hit[IDX_OFF2]) begin
                    vd.set_halt = 1'b1;
                    vd.xoff_ev  = 1'b1;
                end else if (hit[IDX_ON2]) begin
                    vd.clr_halt = 1'b1;
                end else begin
                    vd.wr_cur = 1'b1;
                end
            end
            MODE_PAIR: begin
                if (hold == HOLD_OFF) begin
                    vd.disarm = 1'b1;
                    if (hit[IDX_OFF2]) begin
                        vd.set_halt = 1'b1;
                        vd.xoff_ev  = 1'b1;
                    end else begin
                        vd.flush  = 1'b1;
                        vd.wr_cur = 1'b1;
                    end
                end else if (hold == HOLD_ON) begin
                    vd.disarm = 1'b1;
                    if (hit[IDX_ON2]) begin
                        vd.clr_halt = 1'b1;
                    end else begin
                        vd.flush  = 1'b1;
                        vd.wr_cur = 1'b1;
                    end
                end else if (hit[IDX_OFF1]) begin
                    vd.arm_off = 1'b1;
                end else if (hit[IDX_ON1]) begin
                    vd.arm_on = 1'b1;
                end else begin
                    vd.wr_cur = 1'b1;
                end
            end
            default: vd.wr_cur = 1'b1;
        endcase
    end
endmodule

// File: rtl/xfc_emit.sv
// FIFO write stage: registers one write per cycle and, when a broken pair
// is flushed, writes the held byte first and the current byte next cycle.
// Assumes no rx_valid in the cycle directly after a valid strobe.
module xfc_emit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr_cur,
    input  logic              flush,
    input  logic [DATA_W-1:0] cur_data,
    input  logic [DATA_W-1:0] held_data,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data
);
    logic              pend_v;
    logic [DATA_W-1:0] pend_d;

    // Drive the FIFO write port and the one-deep pending slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            pend_v    <= 1'b0;
            pend_d    <= '0;
        end else if (go && flush) begin
            fifo_wr   <= 1'b1;
            fifo_data <= held_data;
            pend_v    <= 1'b1;
            pend_d    <= cur_data;
        end else if (go && wr_cur) begin
            fifo_wr   <= 1'b1;
            fifo_data <= cur_data;
            pend_v    <= 1'b0;
        end else if (pend_v) begin
            fifo_wr   <= 1'b1;
            fifo_data <= pend_d;
            pend_v    <= 1'b0;
        end else begin
            fifo_wr   <= 1'b0;
        end
    end
endmodule

// File: rtl/xon_xoff_rx_detect.sv
// Top of the software flow-control receive detector. Holds the transmit
// halt flag, the paired-mode first-character state, the sticky special
// status and the interrupt pulses. Assumes the mode is stable while a
// pair is held and that valid strobes are at least two cycles apart.
module xon_xoff_rx_detect
    import xfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] on1_char,
    input  logic [DATA_W-1:0] on2_char,
    input  logic [DATA_W-1:0] off1_char,
    input  logic [DATA_W-1:0] off2_char,
    input  logic [1:0]        fc_mode,
    input  logic              spec_en,
    input  logic              spec_ie,
    input  logic              stat_clr,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              tx_halt,
    output logic              xoff_irq,
    output logic              spec_irq,
    output logic              spec_stat
);
    logic [NUM_CHARS-1:0][DATA_W-1:0] chars;
    logic [NUM_CHARS-1:0]             hit;
    verdict_t                         vd;
    hold_e                            hold_q;
    logic [DATA_W-1:0]                held_q;

    // Gather the match characters in index order.
    always_comb begin
        chars[IDX_ON1]  = on1_char;
        chars[IDX_ON2]  = on2_char;
        chars[IDX_OFF1] = off1_char;
        chars[IDX_OFF2] = off2_char;
    end

    xfc_match #(.DATA_W(DATA_W)) i_match (
        .rx_data (rx_data),
        .chars   (chars),
        .hit     (hit)
    );

    xfc_decide i_decide (
        .mode    (fc_mode),
        .hold    (hold_q),
        .hit     (hit),
        .spec_en (spec_en),
        .vd      (vd)
    );

    xfc_emit #(.DATA_W(DATA_W)) i_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rx_valid),
        .wr_cur    (vd.wr_cur),
        .flush     (vd.flush),
        .cur_data  (rx_data),
        .held_data (held_q),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data)
    );

    // Track the held first character of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HOLD_NONE;
            held_q <= '0;
        end else if (rx_valid) begin
            if (vd.arm_off) begin
                hold_q <= HOLD_OFF;
                held_q <= rx_data;
            end else if (vd.arm_on) begin
                hold_q <= HOLD_ON;
                held_q <= rx_data;
            end else if (vd.disarm) begin
                hold_q <= HOLD_NONE;
            end
        end
    end

    // Maintain the transmit halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                        tx_halt <= 1'b0;
        else if (rx_valid && vd.set_halt) tx_halt <= 1'b1;
        else if (rx_valid && vd.clr_halt) tx_halt <= 1'b0;
    end

    // Issue one-cycle interrupt pulses after a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_irq <= 1'b0;
            spec_irq <= 1'b0;
        end else begin
            xoff_irq <= rx_valid & vd.xoff_ev;
            spec_irq <= rx_valid & vd.spec_ev & spec_ie;
        end
    end

    // Sticky special-character status; a new hit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       spec_stat <= 1'b0;
        else if (rx_valid && vd.spec_ev) spec_stat <= 1'b1;
        else if (stat_clr)               spec_stat <= 1'b0;
    end
endmodule

// File: rtl/xfc_chk.sv
// Checker for the receive detector, attached to the top by bind.
// Observes only the top-level ports.
module xfc_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic [DATA_W-1:0] on1_char,
    input logic [DATA_W-1:0] on2_char,
    input logic [DATA_W-1:0] off1_char,
    input logic [DATA_W-1:0] off2_char,
    input logic [1:0]        fc_mode,
    input logic              spec_en,
    input logic              spec_ie,
    input logic              stat_clr,
    input logic              fifo_wr,
    input logic [DATA_W-1:0] fifo_data,
    input logic              tx_halt,
    input logic              xoff_irq,
    input logic              spec_irq,
    input logic              spec_stat
);
    // R1
    off_mode_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_valid) && $past(fc_mode) == 2'b00) |-> (fifo_wr && fifo_data == $past(rx_data) && !xoff_irq));

    // R3
    sec_halt_not_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_valid) && $past(fc_mode) == 2'b01 && $past(rx_data) == $past(off2_char)) |-> (!fifo_wr && xoff_irq && tx_halt));

    // R9
    xoff_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_irq |=> !xoff_irq);

    // R9
    pulse_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_irq || spec_irq) |-> $past(rx_valid));

    // R11
    halt_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> xoff_irq);

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> $stable(tx_halt));

    // R6
    spec_irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_irq |-> spec_stat);

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spec_stat) && !$past(stat_clr)) |-> spec_stat);
endmodule

bind xon_xoff_rx_detect xfc_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_xon_xoff_rx_detect.sv
module test_xon_xoff_rx_detect;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] on1_char = 8'h11, on2_char = 8'h12, off1_char = 8'h13, off2_char = 8'h93;
    logic [1:0]    fc_mode = 2'b00;
    logic          spec_en = 1'b0, spec_ie = 1'b0, stat_clr = 1'b0;
    logic          fifo_wr, tx_halt, xoff_irq, spec_irq, spec_stat;
    logic [DW-1:0] fifo_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    bit      m_halt = 0, m_stat = 0;
    int      m_hold = 0;           // 0 none, 1 resume held, 2 halt held
    logic [DW-1:0] m_held = '0;

    always #4 clk = ~clk;          // 125 MHz

    xon_xoff_rx_detect #(.DATA_W(DW)) i_xon_xoff_rx_detect (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; rx_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_halt = 0; m_stat = 0; m_hold = 0;
        chk(!tx_halt, "R10 halt", tx_halt, 0);
        chk(!spec_stat, "R10 status", spec_stat, 0);
        chk(!fifo_wr && !xoff_irq && !spec_irq, "R10 outputs", {fifo_wr, xoff_irq, spec_irq}, 0);
    endtask

    // Send one byte, compute expectations from the requirements, check.
    task automatic send(input logic [DW-1:0] b, input bit clr, input string req);
        bit w0 = 0, w1 = 0, ex = 0, es;
        logic [DW-1:0] d0 = '0, d1 = '0;
        bit hoff1 = (b == off1_char), hon1 = (b == on1_char);
        bit hoff2 = (b == off2_char), hon2 = (b == on2_char);
        bit sp = spec_en && hoff2;
        case (fc_mode)
            2'b00: begin w0 = 1; d0 = b; end
            2'b10: if (hoff1) begin m_halt = 1; ex = 1; end
                   else if (hon1) m_halt = 0;
                   else begin w0 = 1; d0 = b; end
            2'b01: if (hoff2) begin m_halt = 1; ex = 1; end
                   else if (hon2) m_halt = 0;
                   else begin w0 = 1; d0 = b; end
            default: begin
                if (m_hold == 2) begin
                    if (hoff2) begin m_halt = 1; ex = 1; end
                    else begin w0 = 1; d0 = m_held; w1 = 1; d1 = b; end
                    m_hold = 0;
                end else if (m_hold == 1) begin
                    if (hon2) m_halt = 0;
                    else begin w0 = 1; d0 = m_held; w1 = 1; d1 = b; end
                    m_hold = 0;
                end else if (hoff1) begin m_hold = 2; m_held = b; end
                else if (hon1) begin m_hold = 1; m_held = b; end
                else begin w0 = 1; d0 = b; end
            end
        endcase
        es = sp && spec_ie;
        m_stat = (clr ? 1'b0 : m_stat) | sp;
        @(negedge clk); rx_data = b; rx_valid = 1'b1; stat_clr = clr;
        @(negedge clk); rx_valid = 1'b0; stat_clr = 1'b0;
        chk(fifo_wr == w0, req, fifo_wr, w0);
        if (w0) chk(fifo_data == d0, req, fifo_data, d0);
        chk(xoff_irq == ex, req, xoff_irq, ex);
        chk(spec_irq == es, req, spec_irq, es);
        chk(tx_halt == m_halt, req, tx_halt, m_halt);
        chk(spec_stat == m_stat, req, spec_stat, m_stat);
        @(negedge clk);
        chk(fifo_wr == w1, req, fifo_wr, w1);
        if (w1) chk(fifo_data == d1, req, fifo_data, d1);
        chk(!xoff_irq && !spec_irq, "R9 pulse width", {xoff_irq, spec_irq}, 0);
    endtask

    task automatic clear_stat();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0; m_stat = 0;
        chk(!spec_stat, "R8 clear", spec_stat, 0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        do_reset();
        // R1
        fc_mode = 2'b00;
        send(off1_char, 0, "R1 off mode halt char");
        send(on2_char, 0, "R1 off mode resume char");
        send(8'h41, 0, "R1 off mode data");
        // R2 and R11
        fc_mode = 2'b10;
        send(off1_char, 0, "R2 halt");
        send(8'h42, 0, "R11 data while halted");
        send(on2_char, 0, "R11 wrong resume");
        send(on1_char, 0, "R2 resume");
        // R3
        fc_mode = 2'b01;
        send(off1_char, 0, "R3 other char");
        send(off2_char, 0, "R3 halt");
        send(on2_char, 0, "R3 resume");
        // R7
        spec_en = 1; spec_ie = 1;
        send(off2_char, 0, "R7 special in secondary");
        clear_stat();
        // R6
        fc_mode = 2'b10;
        send(off2_char, 0, "R6 special written");
        send(8'h43, 1, "R8 clear with data");
        send(off2_char, 1, "R8 set wins over clear");
        spec_ie = 0;
        send(off2_char, 0, "R6 no irq when disabled");
        spec_ie = 1;
        // R4
        fc_mode = 2'b11;
        send(off1_char, 0, "R4 first halt");
        send(off2_char, 0, "R4 pair halt");
        send(on1_char, 0, "R4 first resume");
        send(on2_char, 0, "R4 pair resume");
        // R5
        send(off1_char, 0, "R5 arm");
        send(8'h44, 0, "R5 broken by data");
        send(on1_char, 0, "R5 arm resume");
        send(off2_char, 0, "R5 broken by special");
        send(off1_char, 0, "R5 arm");
        send(on2_char, 0, "R5 wrong partner");
        // R10 reset mid-pair
        send(off1_char, 0, "R10 arm");
        do_reset();
        send(off2_char, 0, "R10 pair cleared by reset");
        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [DW-1:0] b;
            int r;
            if (i % 16 == 0 && m_hold == 0) begin
                fc_mode = 2'($urandom_range(0, 3));
                spec_en = 1'($urandom_range(0, 1));
                spec_ie = 1'($urandom_range(0, 1));
            end
            r = $urandom_range(0, 5);
            case (r)
                0: b = on1_char;
                1: b = on2_char;
                2: b = off1_char;
                3: b = off2_char;
                default: b = 8'($urandom);
            endcase
            send(b, ($urandom_range(0, 7) == 0), "R1 R2 R3 R4 R5 R6 R7 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule